// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block joins two 8-bit bidirectional buses, called A and B. Each direction has its own edge-triggered holding register with its own capture clock. The A-side register samples the A bus, and the B-side register samples the B bus. The output stage for each direction has a select that chooses what it drives onto the far bus: either the live value sensed on the near bus, or the value held in that direction's register. Each direction also has an output enable. The A-to-B enable is active high and the B-to-A enable is active low. Because the enables have opposite polarity, setting both pins low or both pins high turns on exactly one direction.

Each bus pin is split into a sensed input, a driven output and an output-enable, so the design needs no tri-state nets. A thin resolution model sits at the top level, one instance per bus. It combines an external driver with the transceiver's own drive. When nothing drives a bus, the bus keeps its last value. When both the external driver and the transceiver drive a bus with different values, the model flags a clash.

Top module: `dual_reg_xcvr`

## Requirements
- R1: A synchronous active-low reset, applied on the rising edge of each capture clock, clears both holding registers to zero. After reset, a stored-mode output drives 0x00.
- R2: The transceiver drives bus B (`xcvrDrivesB` = 1) exactly when `enAtoB` is 1.
- R3: The transceiver drives bus A (`xcvrDrivesA` = 1) exactly when `enBtoAN` is 0.
- R4: On every rising edge of `capAClk`, the A register loads the value sensed on bus A, whatever the enable and select settings are, including isolation.
- R5: On every rising edge of `capBClk`, the B register loads the value sensed on bus B, whatever the enable and select settings are.
- R6: With `selAtoB` = 0 and B driven, bus B follows the sensed A value combinationally, within the same cycle and with no clock edge.
- R7: With `selBtoA` = 0 and A driven, bus A follows the sensed B value combinationally.
- R8: With `selAtoB` = 1 and B driven, bus B shows the A register. A change on bus A alone does not alter bus B until the next `capAClk` rising edge.
- R9: With `enAtoB` = 1, `enBtoAN` = 0 and both selects at 1, the A register drives B and the B register drives A at the same time.
- R10: With `enAtoB` = 0 and `enBtoAN` = 1, neither bus is driven by the transceiver. A bus with no driver keeps its last value.
- R11: With both directions enabled in live mode, once the external driver releases, both buses hold the last driven value and no clash is flagged.
- R12: A clash flag rises when the external driver and the transceiver both drive a bus with different values. Equal values raise no flag, and the external value is what the bus shows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| busClk | input | 1 | Clock of the bus-hold resolution model |
| rstN | input | 1 | Synchronous active-low reset |
| capAClk | input | 1 | Capture clock of the A-side register |
| capBClk | input | 1 | Capture clock of the B-side register |
| enAtoB | input | 1 | Drive enable toward bus B, active high |
| enBtoAN | input | 1 | Drive enable toward bus A, active low |
| selAtoB | input | 1 | 0: live A value onto B, 1: stored A value onto B |
| selBtoA | input | 1 | 0: live B value onto A, 1: stored B value onto A |
| extAData | input | 8 | External data offered to bus A |
| extADrive | input | 1 | External driver on bus A active |
| extBData | input | 8 | External data offered to bus B |
| extBDrive | input | 1 | External driver on bus B active |
| busA | output | 8 | Resolved value of bus A |
| busB | output | 8 | Resolved value of bus B |
| xcvrDrivesA | output | 1 | Transceiver output enable on bus A |
| xcvrDrivesB | output | 1 | Transceiver output enable on bus B |
| clashA | output | 1 | Conflicting drivers on bus A |
| clashB | output | 1 | Conflicting drivers on bus B |

## Verification
The hardest state to reach is the self-sustaining loop. In that state, both directions are enabled in live mode and nothing external drives either bus, yet both buses must still hold a value and show no clash. To reach it, the stimulus first drives bus A from outside with both paths live. It then waits several bus-model cycles so the value travels to B and back around the loop. Only after that does it release the external driver, and it checks that both buses keep the value. The stored-mode test changes bus A between capture pulses, which shows that bus B waits for the capture edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic storedToA;
    logic storedToB;
  } xcvr_strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         enAtoB,
  input  logic         enBtoAN,
  input  logic         selAtoB,
  input  logic         selBtoA,
  output xcvr_strobe_t strobes
);
  always_comb begin
    strobes.driveB    = enAtoB;
    strobes.driveA    = ~enBtoAN;
    strobes.storedToB = selAtoB;
    strobes.storedToA = selBtoA;
  end
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              capAClk,
  input  logic              capBClk,
  input  logic              rstN,
  input  xcvr_strobe_t      strobes,
  input  logic [DATA_W-1:0] aSense,
  input  logic [DATA_W-1:0] bSense,
  output logic [DATA_W-1:0] aOut,
  output logic              aOe,
  output logic [DATA_W-1:0] bOut,
  output logic              bOe
);
  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regB;

  always_ff @(posedge capAClk) begin
    if (!rstN) regA <= '0;
    else       regA <= aSense;
  end

  always_ff @(posedge capBClk) begin
    if (!rstN) regB <= '0;
    else       regB <= bSense;
  end

  always_comb begin
    bOut = strobes.storedToB ? regA : aSense;
    aOut = strobes.storedToA ? regB : bSense;
    bOe  = strobes.driveB;
    aOe  = strobes.driveA;
  end

  p_cap_a_r4: assert property (@(posedge capAClk) disable iff (!rstN)
    1'b1 |=> regA == $past(aSense));
  p_cap_b_r5: assert property (@(posedge capBClk) disable iff (!rstN)
    1'b1 |=> regB == $past(bSense));
endmodule

// File: rtl/bus_hold_net.sv
module bus_hold_net #(
  parameter int DATA_W = 8
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] extData,
  input  logic              extDrive,
  input  logic [DATA_W-1:0] xcvrData,
  input  logic              xcvrDrive,
  output logic [DATA_W-1:0] sense,
  output logic [DATA_W-1:0] bus,
  output logic              clash
);
  logic [DATA_W-1:0] holdVal;

  always_ff @(posedge busClk) begin
    if (!rstN) holdVal <= '0;
    else       holdVal <= bus;
  end

  always_comb begin
    sense = extDrive ? extData : holdVal;
    if (extDrive)       bus = extData;
    else if (xcvrDrive) bus = xcvrData;
    else                bus = holdVal;
    clash = extDrive && xcvrDrive && (extData != xcvrData);
  end
endmodule

// File: rtl/dual_reg_xcvr.sv
module dual_reg_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              capAClk,
  input  logic              capBClk,
  input  logic              enAtoB,
  input  logic              enBtoAN,
  input  logic              selAtoB,
  input  logic              selBtoA,
  input  logic [DATA_W-1:0] extAData,
  input  logic              extADrive,
  input  logic [DATA_W-1:0] extBData,
  input  logic              extBDrive,
  output logic [DATA_W-1:0] busA,
  output logic [DATA_W-1:0] busB,
  output logic              xcvrDrivesA,
  output logic              xcvrDrivesB,
  output logic              clashA,
  output logic              clashB
);
  xcvr_strobe_t      strobes;
  logic [DATA_W-1:0] aSense, bSense, aOut, bOut;
  logic              aOe, bOe;

  xcvr_ctrl u_ctrl (
    .enAtoB(enAtoB), .enBtoAN(enBtoAN), .selAtoB(selAtoB), .selBtoA(selBtoA),
    .strobes(strobes)
  );

  xcvr_datapath #(.DATA_W(DATA_W)) u_dp (
    .capAClk(capAClk), .capBClk(capBClk), .rstN(rstN), .strobes(strobes),
    .aSense(aSense), .bSense(bSense),
    .aOut(aOut), .aOe(aOe), .bOut(bOut), .bOe(bOe)
  );

  bus_hold_net #(.DATA_W(DATA_W)) u_netA (
    .busClk(busClk), .rstN(rstN), .extData(extAData), .extDrive(extADrive),
    .xcvrData(aOut), .xcvrDrive(aOe), .sense(aSense), .bus(busA), .clash(clashA)
  );

  bus_hold_net #(.DATA_W(DATA_W)) u_netB (
    .busClk(busClk), .rstN(rstN), .extData(extBData), .extDrive(extBDrive),
    .xcvrData(bOut), .xcvrDrive(bOe), .sense(bSense), .bus(busB), .clash(clashB)
  );

  assign xcvrDrivesA = aOe;
  assign xcvrDrivesB = bOe;

  p_drive_b_r2: assert property (@(posedge busClk) disable iff (!rstN)
    (!enAtoB && !extBDrive) |-> !clashB);
  p_live_ab_r6: assert property (@(posedge busClk) disable iff (!rstN)
    (enAtoB && !selAtoB && !extBDrive) |-> busB == aSense);
  p_live_ba_r7: assert property (@(posedge busClk) disable iff (!rstN)
    (!enBtoAN && !selBtoA && !extADrive) |-> busA == bSense);
  p_float_b_r10: assert property (@(posedge busClk) disable iff (!rstN)
    ($past(!enAtoB && !extBDrive) && !enAtoB && !extBDrive) |-> $stable(busB));
  p_clash_src_r12: assert property (@(posedge busClk) disable iff (!rstN)
    clashA |-> (extADrive && xcvrDrivesA && busA == extAData));
endmodule

// File: tb/test_dual_reg_xcvr.sv
module test_dual_reg_xcvr;
  logic busClk = 1'b0;
  logic rstN = 1'b0;
  logic capAClk = 1'b0, capBClk = 1'b0;
  logic enAtoB = 1'b0, enBtoAN = 1'b1, selAtoB = 1'b0, selBtoA = 1'b0;
  logic [7:0] extAData = 8'h00, extBData = 8'h00;
  logic extADrive = 1'b0, extBDrive = 1'b0;
  logic [7:0] busA, busB;
  logic xcvrDrivesA, xcvrDrivesB, clashA, clashB;
  int total = 0;
  int bad = 0;

  always #2.5 busClk = ~busClk;

  dual_reg_xcvr i_dual_reg_xcvr (
    .busClk(busClk), .rstN(rstN), .capAClk(capAClk), .capBClk(capBClk),
    .enAtoB(enAtoB), .enBtoAN(enBtoAN), .selAtoB(selAtoB), .selBtoA(selBtoA),
    .extAData(extAData), .extADrive(extADrive), .extBData(extBData), .extBDrive(extBDrive),
    .busA(busA), .busB(busB), .xcvrDrivesA(xcvrDrivesA), .xcvrDrivesB(xcvrDrivesB),
    .clashA(clashA), .clashB(clashB)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge busClk);
  endtask

  task automatic pulseA();
    capAClk = 1'b1; #1; capAClk = 1'b0; #1;
  endtask

  task automatic pulseB();
    capBClk = 1'b1; #1; capBClk = 1'b0; #1;
  endtask

  task automatic setMode(input logic ab, input logic baN, input logic sAB, input logic sBA);
    enAtoB = ab; enBtoAN = baN; selAtoB = sAB; selBtoA = sBA;
  endtask

  task automatic testReset();
    rstN = 1'b0; extAData = 8'hFF; extADrive = 1'b1; extBData = 8'hEE; extBDrive = 1'b1;
    pulseA(); pulseB(); settle(3);
    rstN = 1'b1; extADrive = 1'b0; extBDrive = 1'b0;
    setMode(1'b1, 1'b0, 1'b1, 1'b1); settle(1);
    chk("R1 stored A after reset", busB, 8'h00);
    chk("R1 stored B after reset", busA, 8'h00);
  endtask

  task automatic testEnables();
    for (int m = 0; m < 4; m++) begin
      setMode(m[1], m[0], 1'b0, 1'b0); #1;
      chk("R2 B drive enable", {7'd0, xcvrDrivesB}, {7'd0, m[1]});
      chk("R3 A drive enable", {7'd0, xcvrDrivesA}, {7'd0, ~m[0]});
    end
  endtask

  task automatic testLive();
    setMode(1'b1, 1'b1, 1'b0, 1'b0); extADrive = 1'b1;
    extAData = 8'hA5; #1; chk("R6 live A to B", busB, 8'hA5);
    extAData = 8'h3C; #1; chk("R6 live A to B follows", busB, 8'h3C);
    extADrive = 1'b0; settle(2);
    setMode(1'b0, 1'b0, 1'b0, 1'b0); extBDrive = 1'b1;
    extBData = 8'h5A; #1; chk("R7 live B to A", busA, 8'h5A);
    extBData = 8'hC3; #1; chk("R7 live B to A follows", busA, 8'hC3);
    extBDrive = 1'b0; settle(2);
  endtask

  task automatic testIsolation();
    setMode(1'b0, 1'b1, 1'b1, 1'b1);
    extADrive = 1'b1; extAData = 8'h81; extBDrive = 1'b1; extBData = 8'h42; #1;
    pulseA(); pulseB();
    extADrive = 1'b0; extBDrive = 1'b0; settle(3);
    chk("R10 A undriven holds", busA, 8'h81);
    chk("R10 B undriven holds", busB, 8'h42);
    chk("R10 no A drive", {7'd0, xcvrDrivesA}, 8'h00);
    setMode(1'b1, 1'b0, 1'b1, 1'b1); #1;
    chk("R4 captured A in isolation", busB, 8'h81);
    chk("R5 captured B in isolation", busA, 8'h42);
  endtask

  task automatic testStored();
    setMode(1'b1, 1'b1, 1'b1, 1'b0); extADrive = 1'b1; extAData = 8'h17; #1;
    pulseA(); settle(1);
    chk("R8 stored after capture", busB, 8'h17);
    extAData = 8'h99; settle(2);
    chk("R8 bus A change ignored", busB, 8'h17);
    pulseA(); #1;
    chk("R8 updates at capture edge", busB, 8'h99);
    extADrive = 1'b0; settle(2);
  endtask

  task automatic testBoth();
    setMode(1'b0, 1'b1, 1'b0, 1'b0);
    extADrive = 1'b1; extAData = 8'h6D; extBDrive = 1'b1; extBData = 8'hB2; #1;
    pulseA(); pulseB();
    extADrive = 1'b0; extBDrive = 1'b0;
    setMode(1'b1, 1'b0, 1'b1, 1'b1); settle(3);
    chk("R9 stored A on B", busB, 8'h6D);
    chk("R9 stored B on A", busA, 8'hB2);
  endtask

  task automatic testHoldLoop();
    setMode(1'b1, 1'b0, 1'b0, 1'b0); extBDrive = 1'b0;
    extADrive = 1'b1; extAData = 8'h3E; settle(4);
    chk("R11 loop no clash while driven", {7'd0, clashA}, 8'h00);
    extADrive = 1'b0; settle(5);
    chk("R11 A holds", busA, 8'h3E);
    chk("R11 B holds", busB, 8'h3E);
    chk("R11 no clash after release", {6'd0, clashA, clashB}, 8'h00);
  endtask

  task automatic testClash();
    setMode(1'b0, 1'b0, 1'b0, 1'b0);
    extBDrive = 1'b1; extBData = 8'h11; extADrive = 1'b1; extAData = 8'h22; #1;
    chk("R12 clash on differing drive", {7'd0, clashA}, 8'h01);
    chk("R12 external wins", busA, 8'h22);
    extAData = 8'h11; #1;
    chk("R12 no clash on equal drive", {7'd0, clashA}, 8'h00);
    extADrive = 1'b0; extBDrive = 1'b0; setMode(1'b0, 1'b1, 1'b0, 1'b0); settle(2);
  endtask

  initial begin
    testReset();
    testEnables();
    testLive();
    testIsolation();
    testStored();
    testBoth();
    testHoldLoop();
    testClash();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule